// File: doc/BRIEF.md
# Dual QSPI flash connection router

This block sits between the datapath of one quad-SPI controller and two identical serial flash devices, called the lower and the upper device. From a single controller chip select, one serial clock, an 8-bit output bus with per-bit output enables and a configuration word, it produces two active-low chip selects, a clock per device and four IO lanes per device. It also returns read data to the controller.

Three routings exist. With the dual-device enable clear, only the lower device is used and the upper one stays idle. With the dual enable set and the separate-bus enable clear (stacked), both devices sit on one shared clock and lane group. The page bit then picks the one device that sees the controller select, and the lower device is the default. With both enables set (parallel), both devices are selected together, each on its own 4-lane bus. Each 8-bit controller word is split so that the even bits travel on the lower device and the odd bits on the upper device. On reads the two nibbles are woven back into one byte. A new configuration is taken up only while the controller select is high, so a transfer always completes in the routing it started with.

Top module: `dqspi_router`

## Requirements
- R1: The routing is decoded only from configuration bit 30 (dual enable), bit 29 (separate-bus enable) and bit 28 (upper page). No other configuration bit affects any output.
- R2: With bit 30 clear (single), the lower select follows the controller select. The upper select stays high, the upper clock stays low and the upper lanes are undriven, whatever bits 29 and 28 hold.
- R3: In stacked mode (bit 30 set, bit 29 clear) with bit 28 clear, only the lower select follows the controller select and the upper select stays high.
- R4: In stacked mode with bit 28 set, only the upper select follows the controller select and the lower select stays high. Both device clocks follow the controller clock.
- R5: In parallel mode (bits 30 and 29 set), both selects follow the controller select and both clocks follow the controller clock.
- R6: In parallel mode, lower lane k carries controller output bit 2k and upper lane k carries controller output bit 2k+1, together with the matching output enables, for k = 0..3.
- R7: In parallel mode, controller input bit 2k is lower lane k and bit 2k+1 is upper lane k.
- R8: A device whose select is high has all of its lane output enables and lane outputs at 0. In single and stacked modes the selected device's lane k carries controller output bit k and enable k.
- R9: A configuration change made while the controller select is low has no effect until the select has been high at a clock edge. The routing in force is the one loaded at the last clock edge at which the select was high.
- R10: In single and stacked modes, controller input bits 0..3 come from the selected device's lanes and bits 4..7 read 0.
- R11: After reset the routing is single mode, and with the controller select high both device selects are high and no lane is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the configuration hold register |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Requested configuration (bits 30, 29, 28 used) |
| ctrl_cs_n | input | 1 | Controller chip select, active low |
| ctrl_sclk | input | 1 | Controller serial clock |
| ctrl_dout | input | 8 | Controller output data |
| ctrl_doe | input | 8 | Controller output enables, one per data bit |
| ctrl_din | output | 8 | Read data returned to the controller |
| lo_cs_n | output | 1 | Lower device select, active low |
| lo_sclk | output | 1 | Lower device clock |
| lo_io_out | output | 4 | Lower device lane outputs |
| lo_io_oe | output | 4 | Lower device lane output enables |
| lo_io_in | input | 4 | Lower device lane inputs |
| hi_cs_n | output | 1 | Upper device select, active low |
| hi_sclk | output | 1 | Upper device clock |
| hi_io_out | output | 4 | Upper device lane outputs |
| hi_io_oe | output | 4 | Upper device lane output enables |
| hi_io_in | input | 4 | Upper device lane inputs |

## Verification
The hardest case to reach is a configuration change in the middle of a transfer. The wrong routing only shows in the cycles between the request and the next time the select goes high. The stimulus opens a transfer in one mode and swaps the page bit or the mode bits while the select is held low. It then checks that the select, lanes and read path keep their old routing until the select has gone high at an edge. A second stress case sets every configuration bit other than the three decoded bits, so that a stray bit in the decode changes the routing.

// File: rtl/dqspi_pkg.sv
package dqspi_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_STACKED  = 2'd1,
    MODE_PARALLEL = 2'd2
  } route_mode_e;

  // Dual enable off: single, whatever the bus bit says.
  function automatic route_mode_e decode_mode(input logic dual_en, input logic sep_bus);
    if (!dual_en)     return MODE_SINGLE;
    else if (sep_bus) return MODE_PARALLEL;
    else              return MODE_STACKED;
  endfunction

  // Device index 0 = lower, 1 = upper. Is that device routed to the select?
  function automatic logic dev_selected(input route_mode_e mode, input logic upper, input int dev);
    case (mode)
      MODE_PARALLEL: return 1'b1;
      MODE_STACKED:  return (dev == 1) ? upper : !upper;
      default:       return (dev == 0);
    endcase
  endfunction

  // Does the device receive the serial clock at all?
  function automatic logic dev_clocked(input route_mode_e mode, input int dev);
    return (mode != MODE_SINGLE) || (dev == 0);
  endfunction

endpackage

// File: rtl/dqspi_cfg_hold.sv
module dqspi_cfg_hold #(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_cs_n,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [CFG_W-1:0] cfg_q,
  output logic             load_en
);
  // Load only between transfers.
  assign load_en = ctrl_cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_q <= '0;
    else if (load_en) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/dqspi_dev_port.sv
module dqspi_dev_port #(
  parameter int LANES = 4
) (
  input  logic             sel,
  input  logic             clk_en,
  input  logic             ctrl_cs_n,
  input  logic             ctrl_sclk,
  input  logic [LANES-1:0] src_out,
  input  logic [LANES-1:0] src_oe,
  output logic             dev_cs_n,
  output logic             dev_sclk,
  output logic [LANES-1:0] dev_out,
  output logic [LANES-1:0] dev_oe
);
  logic active;
  assign active   = sel && !ctrl_cs_n;
  assign dev_cs_n = sel ? ctrl_cs_n : 1'b1;
  assign dev_sclk = clk_en ? ctrl_sclk : 1'b0;
  assign dev_out  = active ? src_out : '0;
  assign dev_oe   = active ? src_oe  : '0;
endmodule

// File: rtl/dqspi_read_merge.sv
module dqspi_read_merge
  import dqspi_pkg::*;
#(
  parameter int LANES = 4,
  localparam int BUS_W = 2 * LANES
) (
  input  route_mode_e      mode,
  input  logic             upper,
  input  logic [LANES-1:0] lo_in,
  input  logic [LANES-1:0] hi_in,
  output logic [BUS_W-1:0] din
);
  logic [BUS_W-1:0] woven;
  logic [LANES-1:0] picked;

  for (genvar k = 0; k < LANES; k++) begin : g_weave
    assign woven[2*k]   = lo_in[k];
    assign woven[2*k+1] = hi_in[k];
  end

  assign picked = (mode == MODE_STACKED && upper) ? hi_in : lo_in;

  always_comb begin
    if (mode == MODE_PARALLEL) din = woven;
    else                       din = {{(BUS_W-LANES){1'b0}}, picked};
  end
endmodule

// File: rtl/dqspi_router.sv
module dqspi_router
  import dqspi_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int DUAL_BIT  = 30,
  parameter int SEP_BIT   = 29,
  parameter int UPPER_BIT = 28,
  parameter int LANES     = 4,
  localparam int BUS_W    = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             ctrl_cs_n,
  input  logic             ctrl_sclk,
  input  logic [BUS_W-1:0] ctrl_dout,
  input  logic [BUS_W-1:0] ctrl_doe,
  output logic [BUS_W-1:0] ctrl_din,
  output logic             lo_cs_n,
  output logic             lo_sclk,
  output logic [LANES-1:0] lo_io_out,
  output logic [LANES-1:0] lo_io_oe,
  input  logic [LANES-1:0] lo_io_in,
  output logic             hi_cs_n,
  output logic             hi_sclk,
  output logic [LANES-1:0] hi_io_out,
  output logic [LANES-1:0] hi_io_oe,
  input  logic [LANES-1:0] hi_io_in
);
  logic [CFG_W-1:0] act_cfg;
  logic             cfg_load;
  route_mode_e      act_mode;
  logic             act_upper;

  dqspi_cfg_hold #(.CFG_W(CFG_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_cs_n (ctrl_cs_n),
    .cfg_in    (cfg_word),
    .cfg_q     (act_cfg),
    .load_en   (cfg_load)
  );

  assign act_mode  = decode_mode(act_cfg[DUAL_BIT], act_cfg[SEP_BIT]);
  assign act_upper = act_cfg[UPPER_BIT];

  logic             dev_cs_n [2];
  logic             dev_sclk [2];
  logic [LANES-1:0] dev_out  [2];
  logic [LANES-1:0] dev_oe   [2];

  for (genvar d = 0; d < 2; d++) begin : g_dev
    logic [LANES-1:0] src_out;
    logic [LANES-1:0] src_oe;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign src_out[k] = (act_mode == MODE_PARALLEL) ? ctrl_dout[2*k+d] : ctrl_dout[k];
      assign src_oe[k]  = (act_mode == MODE_PARALLEL) ? ctrl_doe[2*k+d]  : ctrl_doe[k];
    end

    dqspi_dev_port #(.LANES(LANES)) u_port (
      .sel       (dev_selected(act_mode, act_upper, d)),
      .clk_en    (dev_clocked(act_mode, d)),
      .ctrl_cs_n (ctrl_cs_n),
      .ctrl_sclk (ctrl_sclk),
      .src_out   (src_out),
      .src_oe    (src_oe),
      .dev_cs_n  (dev_cs_n[d]),
      .dev_sclk  (dev_sclk[d]),
      .dev_out   (dev_out[d]),
      .dev_oe    (dev_oe[d])
    );
  end

  assign lo_cs_n   = dev_cs_n[0];
  assign lo_sclk   = dev_sclk[0];
  assign lo_io_out = dev_out[0];
  assign lo_io_oe  = dev_oe[0];
  assign hi_cs_n   = dev_cs_n[1];
  assign hi_sclk   = dev_sclk[1];
  assign hi_io_out = dev_out[1];
  assign hi_io_oe  = dev_oe[1];

  dqspi_read_merge #(.LANES(LANES)) u_merge (
    .mode  (act_mode),
    .upper (act_upper),
    .lo_in (lo_io_in),
    .hi_in (hi_io_in),
    .din   (ctrl_din)
  );
endmodule

// File: rtl/dqspi_router_chk.sv
module dqspi_router_chk #(
  parameter int CFG_W = 32,
  parameter int LANES = 4,
  localparam int BUS_W = 2 * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_cs_n,
  input logic [1:0]       mode,
  input logic [CFG_W-1:0] act_cfg,
  input logic             lo_cs_n,
  input logic             hi_cs_n,
  input logic             hi_sclk,
  input logic [LANES-1:0] lo_io_oe,
  input logic [LANES-1:0] hi_io_oe,
  input logic [BUS_W-1:0] ctrl_din,
  input logic [LANES-1:0] lo_io_in,
  input logic [LANES-1:0] hi_io_in
);
  // R5
  both_sel_only_parallel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_cs_n && !hi_cs_n) |-> (mode == 2'd2));

  // R2
  upper_idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (hi_cs_n && !hi_sclk && hi_io_oe == '0));

  // R8
  lo_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cs_n |-> (lo_io_oe == '0));

  // R8
  hi_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cs_n |-> (hi_io_oe == '0));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_cs_n |=> $stable(act_cfg));

  // R7
  weave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (ctrl_din[0] == lo_io_in[0] && ctrl_din[1] == hi_io_in[0]));

  // R10
  upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |-> (ctrl_din[BUS_W-1:LANES] == '0));
endmodule

bind dqspi_router dqspi_router_chk #(.CFG_W(CFG_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_cs_n (ctrl_cs_n),
  .mode      (act_mode),
  .act_cfg   (act_cfg),
  .lo_cs_n   (lo_cs_n),
  .hi_cs_n   (hi_cs_n),
  .hi_sclk   (hi_sclk),
  .lo_io_oe  (lo_io_oe),
  .hi_io_oe  (hi_io_oe),
  .ctrl_din  (ctrl_din),
  .lo_io_in  (lo_io_in),
  .hi_io_in  (hi_io_in)
);

// File: tb/dqspi_router_test.sv
module dqspi_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        ctrl_cs_n = 1'b1;
  logic        ctrl_sclk = 1'b0;
  logic [7:0]  ctrl_dout = '0;
  logic [7:0]  ctrl_doe = '0;
  logic [7:0]  ctrl_din;
  logic        lo_cs_n, lo_sclk, hi_cs_n, hi_sclk;
  logic [3:0]  lo_io_out, lo_io_oe, hi_io_out, hi_io_oe;
  logic [3:0]  lo_io_in = '0;
  logic [3:0]  hi_io_in = '0;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dqspi_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .ctrl_cs_n(ctrl_cs_n),
    .ctrl_sclk(ctrl_sclk), .ctrl_dout(ctrl_dout), .ctrl_doe(ctrl_doe),
    .ctrl_din(ctrl_din), .lo_cs_n(lo_cs_n), .lo_sclk(lo_sclk),
    .lo_io_out(lo_io_out), .lo_io_oe(lo_io_oe), .lo_io_in(lo_io_in),
    .hi_cs_n(hi_cs_n), .hi_sclk(hi_sclk), .hi_io_out(hi_io_out),
    .hi_io_oe(hi_io_oe), .hi_io_in(hi_io_in)
  );

  // Reference state: the routing word in force, per R9 and R11.
  logic [31:0] ref_cfg = '0;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n)         ref_cfg = '0;
    else if (ctrl_cs_n) ref_cfg = cfg_word;
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural expectation for every output, compared each cycle.
  task automatic compare_all();
    bit dual, sep, up, par, stk;
    bit sel_lo, sel_hi;
    int e_lo_out, e_lo_oe, e_hi_out, e_hi_oe, e_din;
    string cs_req;
    dual = ref_cfg[30]; sep = ref_cfg[29]; up = ref_cfg[28];
    par = dual && sep;
    stk = dual && !sep;
    sel_lo = par || (stk && !up) || !dual;
    sel_hi = par || (stk && up);
    cs_req = par ? "R5" : (stk ? (up ? "R4" : "R3") : "R2");
    e_lo_out = 0; e_lo_oe = 0; e_hi_out = 0; e_hi_oe = 0; e_din = 0;
    for (int k = 0; k < 4; k++) begin
      if (par) begin
        e_lo_out |= ctrl_dout[2*k]   << k;
        e_lo_oe  |= ctrl_doe[2*k]    << k;
        e_hi_out |= ctrl_dout[2*k+1] << k;
        e_hi_oe  |= ctrl_doe[2*k+1]  << k;
        e_din    |= (lo_io_in[k] << (2*k)) | (hi_io_in[k] << (2*k+1));
      end else begin
        e_lo_out |= ctrl_dout[k] << k;
        e_lo_oe  |= ctrl_doe[k]  << k;
        e_hi_out |= ctrl_dout[k] << k;
        e_hi_oe  |= ctrl_doe[k]  << k;
        e_din    |= (sel_hi ? hi_io_in[k] : lo_io_in[k]) << k;
      end
    end
    if (!(sel_lo && !ctrl_cs_n)) begin e_lo_out = 0; e_lo_oe = 0; end
    if (!(sel_hi && !ctrl_cs_n)) begin e_hi_out = 0; e_hi_oe = 0; end
    cmp(cs_req, "lo_cs_n", lo_cs_n, sel_lo ? ctrl_cs_n : 1);
    cmp(cs_req, "hi_cs_n", hi_cs_n, sel_hi ? ctrl_cs_n : 1);
    cmp(cs_req, "lo_sclk", lo_sclk, ctrl_sclk);
    cmp(cs_req, "hi_sclk", hi_sclk, dual ? ctrl_sclk : 0);
    cmp(par ? "R6" : "R8", "lo_io_out", lo_io_out, e_lo_out);
    cmp(par ? "R6" : "R8", "lo_io_oe",  lo_io_oe,  e_lo_oe);
    cmp(par ? "R6" : "R8", "hi_io_out", hi_io_out, e_hi_out);
    cmp(par ? "R6" : "R8", "hi_io_oe",  hi_io_oe,  e_hi_oe);
    cmp(par ? "R7" : "R10", "ctrl_din", ctrl_din, e_din);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
    compare_all();
  endtask

  task automatic drive_random();
    ctrl_sclk = ~ctrl_sclk;
    ctrl_dout = 8'($urandom);
    ctrl_doe  = 8'($urandom);
    lo_io_in  = 4'($urandom);
    hi_io_in  = 4'($urandom);
  endtask

  // Idle with cfg presented, then a transfer of n cycles.
  task automatic xfer(input logic [31:0] cfg, input int n);
    cfg_word = cfg;
    ctrl_cs_n = 1'b1;
    drive_random();
    tick();
    tick();
    ctrl_cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      drive_random();
      tick();
    end
    ctrl_cs_n = 1'b1;
    ctrl_sclk = 1'b0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    // R11 reset state
    cmp("R11", "lo_cs_n in reset", lo_cs_n, 1);
    cmp("R11", "hi_cs_n in reset", hi_cs_n, 1);
    cmp("R11", "oe in reset", {lo_io_oe, hi_io_oe}, 0);
    rst_n = 1'b1;
    tick();
    ctrl_cs_n = 1'b0;
    tick();
    cmp("R11", "single after reset lo_cs_n", lo_cs_n, 0);
    cmp("R11", "single after reset hi_cs_n", hi_cs_n, 1);
    ctrl_cs_n = 1'b1;
    tick();

    xfer(32'h0000_0000, 12);                 // R2 single
    xfer(32'h3000_0000, 12);                 // R2 bits 29/28 ignored without 30
    xfer(32'h4000_0000, 12);                 // R3 stacked lower
    xfer(32'h5000_0000, 12);                 // R4 stacked upper
    xfer(32'h6000_0000, 16);                 // R5 R6 R7 parallel
    xfer(32'h7000_0000, 16);                 // parallel, page bit irrelevant

    // R1: every undecoded bit set must not change the routing
    cfg_word = 32'h8FFF_FFFF | 32'h4000_0000;
    ctrl_cs_n = 1'b1;
    tick();
    ctrl_cs_n = 1'b0;
    tick();
    cmp("R1", "noise bits lo_cs_n", lo_cs_n, 0);
    cmp("R1", "noise bits hi_cs_n", hi_cs_n, 1);
    xfer(32'hAFFF_FFFF, 8);
    xfer(32'h9FFF_FFFF, 8);

    // R9: stacked lower transfer, page switched mid-transfer
    cfg_word = 32'h4000_0000;
    ctrl_cs_n = 1'b1;
    tick();
    ctrl_cs_n = 1'b0;
    tick();
    cfg_word = 32'h5000_0000;
    for (int i = 0; i < 4; i++) begin
      drive_random();
      tick();
      cmp("R9", "held lo_cs_n", lo_cs_n, 0);
      cmp("R9", "held hi_cs_n", hi_cs_n, 1);
    end
    cfg_word = 32'h6000_0000;
    drive_random();
    tick();
    cmp("R9", "held read path", ctrl_din, {4'h0, lo_io_in});
    ctrl_cs_n = 1'b1;
    tick();
    ctrl_cs_n = 1'b0;
    tick();
    cmp("R9", "applied lo_cs_n", lo_cs_n, 0);
    cmp("R9", "applied hi_cs_n", hi_cs_n, 0);
    // parallel to single mid-transfer
    cfg_word = 32'h0;
    for (int i = 0; i < 4; i++) begin
      drive_random();
      tick();
      cmp("R9", "parallel held hi_cs_n", hi_cs_n, 0);
    end
    ctrl_cs_n = 1'b1;
    tick();

    for (int r = 0; r < 20; r++) xfer({1'b0, 3'($urandom), 28'($urandom)}, 1 + ($urandom % 10));

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule